// File: doc/BRIEF.md
# Pulsed Address Gate with Word Budget

This block sits on the read-address and write-address channels of a 64-bit memory port and throttles traffic in two ways. A free-running period is split into an open window of `on_cycles` clock cycles followed by a shut window of `off_cycles` cycles. New address requests are forwarded only while the window is open. On top of that, every period carries a budget of `word_cap` 64-bit data words. Each admitted burst consumes `len + 1` words. A burst that would overrun what is left of the budget waits for the next period.

The gate stands between an upstream master and a downstream slave. Address, length, valid and ready are passed straight through whenever a request is admitted. Once a request has been forwarded it stays valid downstream until the slave accepts it, even if the window closes or the budget runs dry in the meantime. When a read and a write are both waiting in the same cycle, the read is checked against the budget first and the write gets what remains. Data and response channels do not pass through this block.

Top module: `pulse_addr_gate`

## Requirements
- R1: While reset is asserted, and after reset with no request pending, both downstream valids and both upstream readies are low.
- R2: The first cycle after reset release is cycle 0 of a period. A period lasts `on_cycles + off_cycles` cycles, and a new request can be admitted only in the cycles whose position within the period is below `on_cycles`.
- R3: In the shut part of the period (position at or above `on_cycles`), no new request is forwarded on either channel.
- R4: When `on_cycles` and `off_cycles` are both zero, the gate is permanently open and `word_cap` is ignored.
- R5: A burst with length field `len` costs `len + 1` words. It is admitted only if the words already used in the current period plus its cost do not exceed `word_cap`. The count of used words returns to zero at the start of every period.
- R6: A `word_cap` of zero means there is no word limit.
- R7: When a read and a write are both admissible in the same cycle, the read is charged first and the write is admitted only if it still fits in what remains.
- R8: A forwarded request keeps its downstream valid high until the downstream ready is seen, whatever the window or budget does, and its cost is charged exactly once.
- R9: The upstream ready equals downstream valid and downstream ready together, and address and length are forwarded unchanged.
- R10: A burst whose cost exceeds a nonzero `word_cap` is never forwarded, and it consumes no budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_cycles | input | CNT_W | Length of the open window in cycles |
| off_cycles | input | CNT_W | Length of the shut window in cycles |
| word_cap | input | CNT_W | 64-bit words allowed per period, 0 = unlimited |
| s_ar_valid | input | 1 | Upstream read request valid |
| s_ar_addr | input | ADDR_W | Upstream read address |
| s_ar_len | input | LEN_W | Upstream read burst length minus one |
| s_ar_ready | output | 1 | Upstream read request accepted |
| m_ar_valid | output | 1 | Downstream read request valid |
| m_ar_addr | output | ADDR_W | Downstream read address |
| m_ar_len | output | LEN_W | Downstream read burst length minus one |
| m_ar_ready | input | 1 | Downstream read request accepted |
| s_aw_valid | input | 1 | Upstream write request valid |
| s_aw_addr | input | ADDR_W | Upstream write address |
| s_aw_len | input | LEN_W | Upstream write burst length minus one |
| s_aw_ready | output | 1 | Upstream write request accepted |
| m_aw_valid | output | 1 | Downstream write request valid |
| m_aw_addr | output | ADDR_W | Downstream write address |
| m_aw_len | output | LEN_W | Downstream write burst length minus one |
| m_aw_ready | input | 1 | Downstream write request accepted |

## Verification
The bench sets up windows with a zero shut part and with a zero open part, both lengths zero, caps of 2 to 6 words, and a 4-word burst against a 2-word cap. A design that reloads the budget a cycle late, or that lets an oversize burst consume budget, admits a different number of handshakes. With equal read and write bursts that only fit one at a time, a design that favours writes swaps the two counts. A stalled slave is held across a window close and across the budget limit. A gate that drops valid mid-handshake, or that charges the held request every cycle, shows up as a lost valid or as too few later admissions.

// File: rtl/pag_pkg.sv
package pag_pkg;
    // channel slots used for the per-channel arrays in the top
    localparam int PAG_NCH = 2;
    localparam int PAG_RD  = 0;   // read has priority on the budget
    localparam int PAG_WR  = 1;
endpackage

// File: rtl/pag_window.sv
module pag_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] on_cycles,
    input  logic [CNT_W-1:0] off_cycles,
    output logic             win_open,
    output logic             period_end,
    output logic             always_open
);
    localparam int PW = CNT_W + 1;

    typedef struct packed {
        logic [PW-1:0] pos;
    } win_st_t;

    win_st_t st_q, st_d;
    logic [PW-1:0] period_len;
    logic          last_cyc;

    assign period_len  = {1'b0, on_cycles} + {1'b0, off_cycles};
    assign always_open = (period_len == '0);
    assign last_cyc    = !always_open && (st_q.pos >= period_len - PW'(1));

    always_comb begin
        st_d = st_q;
        if (always_open || last_cyc) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_open   = always_open || (st_q.pos < {1'b0, on_cycles});
    assign period_end = last_cyc;
endmodule

// File: rtl/pag_budget.sv
module pag_budget #(
    parameter int CNT_W = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] word_cap,
    input  logic             always_open,
    input  logic             period_end,
    input  logic             rd_req,
    input  logic [LEN_W-1:0] rd_len,
    input  logic             wr_req,
    input  logic [LEN_W-1:0] wr_len,
    output logic             rd_admit,
    output logic             wr_admit,
    output logic [CNT_W+1:0] used_words
);
    localparam int SW = CNT_W + 2;

    typedef struct packed {
        logic [SW-1:0] used;
    } bud_st_t;

    bud_st_t st_q, st_d;
    logic          no_cap;
    logic [SW-1:0] cap_w;
    logic [SW-1:0] rd_cost, wr_cost;
    logic [SW-1:0] after_rd, after_wr;
    logic          rd_fit, wr_fit;

    assign no_cap  = always_open || (word_cap == '0);
    assign cap_w   = SW'(word_cap);
    assign rd_cost = SW'(rd_len) + SW'(1);
    assign wr_cost = SW'(wr_len) + SW'(1);

    always_comb begin
        st_d     = st_q;
        // read is priced against the budget before the write
        rd_fit   = no_cap || ((st_q.used + rd_cost) <= cap_w);
        rd_admit = rd_req && rd_fit;
        after_rd = rd_admit ? (st_q.used + rd_cost) : st_q.used;
        wr_fit   = no_cap || ((after_rd + wr_cost) <= cap_w);
        wr_admit = wr_req && wr_fit;
        after_wr = wr_admit ? (after_rd + wr_cost) : after_rd;
        if (no_cap || period_end) begin
            st_d.used = '0;
        end else begin
            st_d.used = after_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign used_words = st_q.used;
endmodule

// File: rtl/pag_hold.sv
module pag_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic admit,
    input  logic m_ready,
    output logic m_valid,
    output logic held
);
    typedef struct packed {
        logic pend;
    } hold_st_t;

    hold_st_t st_q, st_d;

    assign m_valid = rst_n && (st_q.pend || admit);

    always_comb begin
        st_d      = st_q;
        // keep the request on the bus until the slave takes it
        st_d.pend = m_valid && !m_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.pend;
endmodule

// File: rtl/pulse_addr_gate.sv
module pulse_addr_gate #(
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  on_cycles,
    input  logic [CNT_W-1:0]  off_cycles,
    input  logic [CNT_W-1:0]  word_cap,
    input  logic              s_ar_valid,
    input  logic [ADDR_W-1:0] s_ar_addr,
    input  logic [LEN_W-1:0]  s_ar_len,
    output logic              s_ar_ready,
    output logic              m_ar_valid,
    output logic [ADDR_W-1:0] m_ar_addr,
    output logic [LEN_W-1:0]  m_ar_len,
    input  logic              m_ar_ready,
    input  logic              s_aw_valid,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [LEN_W-1:0]  s_aw_len,
    output logic              s_aw_ready,
    output logic              m_aw_valid,
    output logic [ADDR_W-1:0] m_aw_addr,
    output logic [LEN_W-1:0]  m_aw_len,
    input  logic              m_aw_ready
);
    import pag_pkg::*;

    logic                 win_open, period_end, always_open;
    logic [PAG_NCH-1:0]   up_valid, dn_ready, dn_valid, held, req, admit;
    logic [LEN_W-1:0]     up_len [PAG_NCH];
    logic [CNT_W+1:0]     used_words;

    assign up_valid[PAG_RD] = s_ar_valid;
    assign up_valid[PAG_WR] = s_aw_valid;
    assign up_len[PAG_RD]   = s_ar_len;
    assign up_len[PAG_WR]   = s_aw_len;
    assign dn_ready[PAG_RD] = m_ar_ready;
    assign dn_ready[PAG_WR] = m_aw_ready;

    pag_window #(.CNT_W(CNT_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_cycles  (on_cycles),
        .off_cycles (off_cycles),
        .win_open   (win_open),
        .period_end (period_end),
        .always_open(always_open)
    );

    pag_budget #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_bud (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_cap   (word_cap),
        .always_open(always_open),
        .period_end (period_end),
        .rd_req     (req[PAG_RD]),
        .rd_len     (up_len[PAG_RD]),
        .wr_req     (req[PAG_WR]),
        .wr_len     (up_len[PAG_WR]),
        .rd_admit   (admit[PAG_RD]),
        .wr_admit   (admit[PAG_WR]),
        .used_words (used_words)
    );

    for (genvar ch = 0; ch < PAG_NCH; ch++) begin : g_ch
        // only a fresh request asks the budget; a held one is already paid
        assign req[ch] = rst_n && up_valid[ch] && !held[ch] && win_open;

        pag_hold u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .admit  (admit[ch]),
            .m_ready(dn_ready[ch]),
            .m_valid(dn_valid[ch]),
            .held   (held[ch])
        );
    end

    assign m_ar_valid = dn_valid[PAG_RD];
    assign m_aw_valid = dn_valid[PAG_WR];
    assign s_ar_ready = dn_valid[PAG_RD] && m_ar_ready;
    assign s_aw_ready = dn_valid[PAG_WR] && m_aw_ready;
    assign m_ar_addr  = s_ar_addr;
    assign m_ar_len   = s_ar_len;
    assign m_aw_addr  = s_aw_addr;
    assign m_aw_len   = s_aw_len;
endmodule

// File: rtl/pag_chk.sv
module pag_chk #(
    parameter int CNT_W = 16,
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] on_cycles,
    input logic [CNT_W-1:0] off_cycles,
    input logic [CNT_W-1:0] word_cap,
    input logic             s_ar_valid,
    input logic [LEN_W-1:0] s_ar_len,
    input logic             s_ar_ready,
    input logic             m_ar_valid,
    input logic             m_ar_ready,
    input logic             s_aw_valid,
    input logic             s_aw_ready,
    input logic             m_aw_valid,
    input logic             m_aw_ready,
    input logic             win_open,
    input logic [1:0]       held,
    input logic [CNT_W+1:0] used_words
);
    logic both_zero;
    assign both_zero = (on_cycles == '0) && (off_cycles == '0);

    // R8
    hold_ar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_ar_valid && !m_ar_ready |=> m_ar_valid);

    // R8
    hold_aw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_aw_valid && !m_aw_ready |=> m_aw_valid);

    // R3
    shut_ar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_ar_valid && !held[0] |-> win_open);

    // R3
    shut_aw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_aw_valid && !held[1] |-> win_open);

    // R4
    open_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        both_zero |-> win_open);

    // R5
    budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cap != '0) && !both_zero |-> used_words <= (CNT_W+2)'(word_cap));

    // R9
    ready_ar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ar_ready |-> s_ar_valid && m_ar_ready);

    // R9
    ready_aw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_aw_ready |-> s_aw_valid && m_aw_ready);

    // R10
    oversize_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cap != '0) && !both_zero && !held[0]
        && ((CNT_W+1)'(s_ar_len) + (CNT_W+1)'(1) > (CNT_W+1)'(word_cap))
        |-> !m_ar_valid);
endmodule

bind pulse_addr_gate pag_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_cycles (on_cycles),
    .off_cycles(off_cycles),
    .word_cap  (word_cap),
    .s_ar_valid(s_ar_valid),
    .s_ar_len  (s_ar_len),
    .s_ar_ready(s_ar_ready),
    .m_ar_valid(m_ar_valid),
    .m_ar_ready(m_ar_ready),
    .s_aw_valid(s_aw_valid),
    .s_aw_ready(s_aw_ready),
    .m_aw_valid(m_aw_valid),
    .m_aw_ready(m_aw_ready),
    .win_open  (win_open),
    .held      (held),
    .used_words(used_words)
);

// File: tb/sim_pulse_addr_gate.sv
module sim_pulse_addr_gate;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam int LEN_W  = 8;
    localparam int ADDR_W = 32;

    typedef struct packed {
        logic [3:0]  rq;
        logic [15:0] on_c;
        logic [15:0] off_c;
        logic [15:0] cap;
        logic        arv;
        logic [7:0]  arl;
        logic        awv;
        logic [7:0]  awl;
        logic [7:0]  ncyc;
        logic [7:0]  exp_ar;
        logic [7:0]  exp_aw;
    } vec_t;

    // each row: from reset, requests held high, slave always ready,
    // handshakes counted over ncyc cycles
    localparam vec_t VECS [10] = '{
        // R2 R6: 4 open / 2 shut, no cap, 256-word bursts
        '{4'd2, 16'd4, 16'd0 + 16'd2, 16'd0, 1'b1, 8'd255, 1'b0, 8'd0, 8'd12, 8'd8, 8'd0},
        // R4: both lengths zero, cap ignored
        '{4'd4, 16'd0, 16'd0, 16'd3, 1'b1, 8'd0, 1'b1, 8'd0, 8'd10, 8'd10, 8'd10},
        // R5: 2-word bursts, cap 6 per 6-cycle period
        '{4'd5, 16'd5, 16'd1, 16'd6, 1'b1, 8'd1, 1'b0, 8'd0, 8'd12, 8'd6, 8'd0},
        // R7: read wins, write no longer fits
        '{4'd7, 16'd8, 16'd0, 16'd3, 1'b1, 8'd1, 1'b1, 8'd1, 8'd8, 8'd1, 8'd0},
        // R7: both fit together when cap is 4
        '{4'd7, 16'd8, 16'd0, 16'd4, 1'b1, 8'd1, 1'b1, 8'd1, 8'd8, 8'd1, 8'd1},
        // R3: open window of zero length keeps the gate shut
        '{4'd3, 16'd0, 16'd5, 16'd0, 1'b1, 8'd0, 1'b1, 8'd0, 8'd10, 8'd0, 8'd0},
        // R5: no shut part, budget reloads every 3 cycles
        '{4'd5, 16'd3, 16'd0, 16'd2, 1'b1, 8'd0, 1'b0, 8'd0, 8'd9, 8'd6, 8'd0},
        // R10: 4-word read against cap 2, writes still use the budget
        '{4'd10, 16'd4, 16'd0, 16'd2, 1'b1, 8'd3, 1'b1, 8'd0, 8'd8, 8'd0, 8'd4},
        // R3: write channel alone, 2 open / 3 shut
        '{4'd3, 16'd2, 16'd3, 16'd0, 1'b0, 8'd0, 1'b1, 8'd0, 8'd10, 8'd0, 8'd4},
        // R2: examples scaled down, 3 open / 1 shut, cap 4
        '{4'd2, 16'd3, 16'd1, 16'd4, 1'b1, 8'd0, 1'b0, 8'd0, 8'd8, 8'd6, 8'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CNT_W-1:0]  on_cycles, off_cycles, word_cap;
    logic              s_ar_valid, s_ar_ready, m_ar_valid, m_ar_ready;
    logic [ADDR_W-1:0] s_ar_addr, m_ar_addr;
    logic [LEN_W-1:0]  s_ar_len, m_ar_len;
    logic              s_aw_valid, s_aw_ready, m_aw_valid, m_aw_ready;
    logic [ADDR_W-1:0] s_aw_addr, m_aw_addr;
    logic [LEN_W-1:0]  s_aw_len, m_aw_len;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_addr_gate #(.CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .on_cycles(on_cycles), .off_cycles(off_cycles), .word_cap(word_cap),
        .s_ar_valid(s_ar_valid), .s_ar_addr(s_ar_addr), .s_ar_len(s_ar_len),
        .s_ar_ready(s_ar_ready), .m_ar_valid(m_ar_valid), .m_ar_addr(m_ar_addr),
        .m_ar_len(m_ar_len), .m_ar_ready(m_ar_ready),
        .s_aw_valid(s_aw_valid), .s_aw_addr(s_aw_addr), .s_aw_len(s_aw_len),
        .s_aw_ready(s_aw_ready), .m_aw_valid(m_aw_valid), .m_aw_addr(m_aw_addr),
        .m_aw_len(m_aw_len), .m_aw_ready(m_aw_ready)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // enter reset at a falling edge with new settings; returns at a falling edge
    task automatic do_reset(input int on_c, input int off_c, input int cap);
        @(negedge clk);
        rst_n      = 1'b0;
        on_cycles  = CNT_W'(on_c);
        off_cycles = CNT_W'(off_c);
        word_cap   = CNT_W'(cap);
        s_ar_valid = 1'b0;
        s_aw_valid = 1'b0;
        m_ar_ready = 1'b1;
        m_aw_ready = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b1;
        on_cycles = '0; off_cycles = '0; word_cap = '0;
        s_ar_valid = 1'b0; s_ar_addr = '0; s_ar_len = '0; m_ar_ready = 1'b1;
        s_aw_valid = 1'b0; s_aw_addr = '0; s_aw_len = '0; m_aw_ready = 1'b1;
        #1 rst_n = 1'b0;

        // vector table
        for (int v = 0; v < 10; v++) begin
            int n_ar;
            int n_aw;
            do_reset(int'(VECS[v].on_c), int'(VECS[v].off_c), int'(VECS[v].cap));
            s_ar_valid = VECS[v].arv;
            s_ar_len   = VECS[v].arl;
            s_ar_addr  = 32'h1000 + 32'(v);
            s_aw_valid = VECS[v].awv;
            s_aw_len   = VECS[v].awl;
            s_aw_addr  = 32'h2000 + 32'(v);
            rst_n      = 1'b1;
            n_ar = 0;
            n_aw = 0;
            for (int c = 0; c < int'(VECS[v].ncyc); c++) begin
                #(CLK_PERIOD/4);
                if (s_ar_ready) n_ar++;
                if (s_aw_ready) n_aw++;
                @(negedge clk);
            end
            check($sformatf("R%0d vec%0d reads", VECS[v].rq, v), n_ar, int'(VECS[v].exp_ar));
            check($sformatf("R%0d vec%0d writes", VECS[v].rq, v), n_aw, int'(VECS[v].exp_aw));
        end

        // R1: outputs low during reset even with requests present
        do_reset(4, 0, 0);
        s_ar_valid = 1'b1;
        s_aw_valid = 1'b1;
        #(CLK_PERIOD/4);
        check("R1 ar valid in reset", int'(m_ar_valid), 0);
        check("R1 aw ready in reset", int'(s_aw_ready), 0);
        @(negedge clk);
        s_ar_valid = 1'b0;
        s_aw_valid = 1'b0;
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        check("R1 idle ar valid", int'(m_ar_valid), 0);
        check("R1 idle aw valid", int'(m_aw_valid), 0);
        @(negedge clk);

        // R8 R9: stalled slave, charge taken once (cap 4, 2-word bursts)
        do_reset(8, 0, 4);
        s_ar_valid = 1'b1;
        s_ar_len   = 8'd1;
        s_ar_addr  = 32'hABCD_0040;
        m_ar_ready = 1'b0;
        rst_n      = 1'b1;
        #(CLK_PERIOD/4);
        check("R8 first forward", int'(m_ar_valid), 1);
        check("R9 addr forwarded", int'(m_ar_addr == 32'hABCD_0040), 1);
        check("R9 len forwarded", int'(m_ar_len), 1);
        @(negedge clk);
        #(CLK_PERIOD/4);
        @(negedge clk);
        #(CLK_PERIOD/4);
        check("R8 still valid while stalled", int'(m_ar_valid), 1);
        check("R9 no ready while stalled", int'(s_ar_ready), 0);
        @(negedge clk);
        m_ar_ready = 1'b1;
        begin
            int hs;
            hs = 0;
            for (int c = 3; c < 8; c++) begin
                #(CLK_PERIOD/4);
                if (s_ar_ready) hs++;
                @(negedge clk);
            end
            check("R8 single charge", hs, 2);
        end

        // R8 R3: held across window close, then shut window blocks
        do_reset(2, 6, 0);
        s_ar_valid = 1'b1;
        s_ar_len   = 8'd0;
        m_ar_ready = 1'b0;
        rst_n      = 1'b1;
        for (int c = 0; c < 5; c++) begin
            #(CLK_PERIOD/4);
            if (c == 4) check("R8 held in shut window", int'(m_ar_valid), 1);
            @(negedge clk);
        end
        m_ar_ready = 1'b1;
        #(CLK_PERIOD/4);
        check("R8 held request accepted", int'(s_ar_ready), 1);
        @(negedge clk);
        #(CLK_PERIOD/4);
        check("R3 new request blocked", int'(m_ar_valid), 0);
        @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule